// File: doc/BRIEF.md
# Tagged Translation Cache with Scoped Invalidation

This block holds a small set of completed address translations, so one table walk can serve many later memory accesses. Each entry carries a virtual page tag, a 16-bit address-space identifier, a global flag, a mapping-size code, a physical frame and an attribute field. A lookup presents a virtual address and the current address-space identifier. In the same cycle it returns hit or miss, the translated physical address and the stored attributes. Permission decisions downstream are made from these cached attributes.

A fill port writes the result of a walk that finished without a translation or access-flag fault. A free slot is chosen first. When no slot is free, a round-robin pointer picks the victim. An invalidation port removes entries with one of four scopes, and each scope treats global mappings in its own way. Cached contents are never refreshed on their own. An entry stays usable until an invalidation removes it, even if the backing table has changed.

Top module: `tlbt_top`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and `lk_pa` and `lk_attr` read zero.
- R2: A lookup hits when it matches a valid entry. On a hit, `lk_pa` and `lk_attr` return the stored frame and attributes in the same cycle as the lookup inputs. A fill becomes visible from the cycle after its clock edge.
- R3: A non-global entry hits only when the lookup identifier equals the stored one. A global entry (`fill_global`=1) hits for every identifier.
- R4: The size code sets the number of untranslated low bits b: 0→12, 1→14, 2→16, 3→21, 4→25, 5→29, 6→30, 7→42. Only VA bits 55:b are compared. PA bits b-1:0 come from the lookup VA, and PA bits 47:b come from the stored frame.
- R5: Invalidation op 0 removes every entry.
- R6: Invalidation op 1 removes non-global entries whose identifier equals `inv_asid`. Global entries stay.
- R7: Invalidation op 2 removes non-global entries with identifier `inv_asid` whose page matches `inv_page`. It also removes any global entry whose page matches.
- R8: Invalidation op 3 removes every entry whose page matches `inv_page`, whatever its identifier or global flag.
- R9: `inv_page` bit k stands for VA bit k+12. A page matches when VA bits 55:b agree, using the entry's own b. An operand anywhere inside a block therefore removes that block.
- R10: When an invalidation and a fill occur in the same cycle, the invalidation is applied first. The filled entry is then present.
- R11: A fill takes the lowest-numbered free slot. When all 16 slots are valid, it replaces the slot at a round-robin pointer. The pointer starts at 0 after reset and advances by one only on such a replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | 56 | Lookup virtual address |
| lk_asid | input | 16 | Current address-space identifier |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_pa | output | 48 | Translated physical address (zero on miss) |
| lk_attr | output | 10 | Stored attributes (zero on miss) |
| fill_en | input | 1 | Write a new entry this cycle |
| fill_vpn | input | 44 | Virtual page number (VA 55:12) of the fill |
| fill_asid | input | 16 | Identifier of the fill |
| fill_global | input | 1 | Fill is global |
| fill_size | input | 3 | Mapping-size code of the fill |
| fill_pfn | input | 36 | Physical frame (PA 47:12) of the fill |
| fill_attr | input | 10 | Attributes of the fill |
| inv_en | input | 1 | Perform an invalidation this cycle |
| inv_op | input | 2 | Invalidation scope: 0 all, 1 identifier, 2 page in identifier, 3 page in any identifier |
| inv_asid | input | 16 | Identifier operand |
| inv_page | input | 44 | Page operand, bits map to VA 55:12 |

## Verification
Several properties are checked on every cycle. The table is empty after reset and after an invalidate-all with no fill. An identifier-scoped invalidation never drops a global entry. A fill always lands in a valid slot. The victim selector never passes over a free slot. Any hit preserves the 4 KiB page offset. Only the bench scenarios can show the rest: the exact PA composition for each size code, the page and identifier scoping of each invalidation kind, block removal by an interior page operand, and the order of round-robin eviction.

// File: rtl/tlbt_pkg.sv
package tlbt_pkg;
    parameter int VA_W   = 56;
    parameter int PA_W   = 48;
    parameter int ASID_W = 16;
    parameter int ATTR_W = 10;
    parameter int PG_SH  = 12;
    localparam int VPN_W = VA_W - PG_SH;
    localparam int PFN_W = PA_W - PG_SH;

    typedef enum logic [1:0] {
        INV_ALL       = 2'd0,
        INV_ASID      = 2'd1,
        INV_PAGE_ASID = 2'd2,
        INV_PAGE_ANY  = 2'd3
    } inv_op_e;

    typedef logic [2:0] size_t;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        size_t             size;
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
    } entry_t;

    // untranslated low-bit count for each size code
    function automatic int size_bits(size_t s);
        case (s)
            3'd0:    return 12;
            3'd1:    return 14;
            3'd2:    return 16;
            3'd3:    return 21;
            3'd4:    return 25;
            3'd5:    return 29;
            3'd6:    return 30;
            default: return 42;
        endcase
    endfunction

    // ones on the page-number bits that take part in a compare
    function automatic logic [VPN_W-1:0] vpn_mask(size_t s);
        return {VPN_W{1'b1}} << (size_bits(s) - PG_SH);
    endfunction
endpackage

// File: rtl/tlbt_match.sv
module tlbt_match
    import tlbt_pkg::*;
(
    input  entry_t            ent,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              inv_en,
    input  inv_op_e           inv_op,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VPN_W-1:0]  inv_vpn,
    output logic              lk_hit,
    output logic              inv_hit
);
    logic [VPN_W-1:0] mask;
    logic             page_eq;
    logic             asid_inv_eq;

    always_comb begin
        mask        = vpn_mask(ent.size);
        page_eq     = ((ent.vpn ^ inv_vpn) & mask) == '0;
        asid_inv_eq = ent.asid == inv_asid;
        lk_hit      = ent.valid && (((ent.vpn ^ lk_vpn) & mask) == '0)
                      && (ent.glob || ent.asid == lk_asid);
        inv_hit     = 1'b0;
        if (inv_en && ent.valid) begin
            case (inv_op)
                INV_ALL:       inv_hit = 1'b1;
                INV_ASID:      inv_hit = !ent.glob && asid_inv_eq;
                INV_PAGE_ASID: inv_hit = page_eq && (ent.glob || asid_inv_eq);
                default:       inv_hit = page_eq;
            endcase
        end
    end
endmodule

// File: rtl/tlbt_victim.sv
module tlbt_victim #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [N_ENT-1:0] free_vec,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = |free_vec;
        for (int i = N_ENT - 1; i >= 0; i--)
            if (free_vec[i]) free_idx = IDX_W'(i);
        victim_idx = any_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (fill_en && !any_free)
            rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
    end

    // R11
    free_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (|free_vec) |-> free_vec[victim_idx]);
endmodule

// File: rtl/tlbt_top.sv
module tlbt_top
    import tlbt_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [2:0]        fill_size,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic              inv_en,
    input  logic [1:0]        inv_op,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VPN_W-1:0]  inv_page
);
    entry_t           ent_q [N_ENT];
    logic [N_ENT-1:0] hit_v, inv_v, free_v, valid_v, gvalid_v;
    logic [IDX_W-1:0] vic_idx, sel;
    logic [VPN_W-1:0] lk_vpn, m;
    inv_op_e          op;
    entry_t           new_ent;

    assign lk_vpn = lk_va[VA_W-1:PG_SH];
    assign op     = inv_op_e'(inv_op);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        tlbt_match u_match (
            .ent      (ent_q[i]),
            .lk_vpn   (lk_vpn),
            .lk_asid  (lk_asid),
            .inv_en   (inv_en),
            .inv_op   (op),
            .inv_asid (inv_asid),
            .inv_vpn  (inv_page),
            .lk_hit   (hit_v[i]),
            .inv_hit  (inv_v[i])
        );
        assign valid_v[i]  = ent_q[i].valid;
        assign gvalid_v[i] = ent_q[i].valid & ent_q[i].glob;
        assign free_v[i]   = ~(ent_q[i].valid & ~inv_v[i]);
    end

    tlbt_victim #(.N_ENT(N_ENT)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .fill_en    (fill_en),
        .free_vec   (free_v),
        .victim_idx (vic_idx)
    );

    always_comb begin
        new_ent = '{valid: 1'b1, glob: fill_global, asid: fill_asid,
                    vpn: fill_vpn, size: fill_size, pfn: fill_pfn,
                    attr: fill_attr};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++)
                if (inv_v[i]) ent_q[i].valid <= 1'b0;
            if (fill_en) ent_q[vic_idx] <= new_ent;
        end
    end

    always_comb begin
        sel = '0;
        for (int i = N_ENT - 1; i >= 0; i--)
            if (hit_v[i]) sel = IDX_W'(i);
        lk_hit  = |hit_v;
        m       = vpn_mask(ent_q[sel].size);
        lk_pa   = '0;
        lk_attr = '0;
        if (lk_hit) begin
            lk_pa   = {(ent_q[sel].pfn & m[PFN_W-1:0]) |
                       (lk_vpn[PFN_W-1:0] & ~m[PFN_W-1:0]),
                       lk_va[PG_SH-1:0]};
            lk_attr = ent_q[sel].attr;
        end
    end

    // R1
    rst_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_v == '0));
    // R5
    inv_all_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_en && op == INV_ALL && !fill_en) |=> (valid_v == '0));
    // R6
    asid_keeps_global_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_en && op == INV_ASID && !fill_en) |=>
        (($past(gvalid_v) & ~valid_v) == '0));
    // R10
    fill_lands_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_v[$past(vic_idx)]);
    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_pa[PG_SH-1:0] == lk_va[PG_SH-1:0]));
endmodule

// File: tb/tlbt_top_tb_top.sv
`timescale 1ns/1ps
module tlbt_top_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic [55:0] lk_va = '0;
    logic [15:0] lk_asid = '0;
    logic        lk_hit;
    logic [47:0] lk_pa;
    logic [9:0]  lk_attr;
    logic        fill_en = 0;
    logic [43:0] fill_vpn = '0;
    logic [15:0] fill_asid = '0;
    logic        fill_global = 0;
    logic [2:0]  fill_size = '0;
    logic [35:0] fill_pfn = '0;
    logic [9:0]  fill_attr = '0;
    logic        inv_en = 0;
    logic [1:0]  inv_op = '0;
    logic [15:0] inv_asid = '0;
    logic [43:0] inv_page = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tlbt_top dut_i (.*);

    function automatic int bits_of(input int s);
        int t [8] = '{12, 14, 16, 21, 25, 29, 30, 42};
        return t[s];
    endfunction

    function automatic logic [47:0] exp_pa(input logic [55:0] va, input int s,
                                           input logic [35:0] pfn);
        logic [47:0] low;
        low = (48'd1 << bits_of(s)) - 48'd1;
        return ({pfn, 12'h000} & ~low) | (48'(va) & low);
    endfunction

    function automatic logic [9:0] attr_of(input logic [35:0] pfn);
        return pfn[9:0] ^ 10'h2A5;
    endfunction

    task automatic fill(input logic [55:0] va, input logic [15:0] asid,
                        input logic g, input int s, input logic [35:0] pfn);
        @(negedge clk);
        fill_en = 1; fill_vpn = va[55:12]; fill_asid = asid;
        fill_global = g; fill_size = 3'(s); fill_pfn = pfn; fill_attr = attr_of(pfn);
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic inv(input logic [1:0] op, input logic [15:0] asid,
                       input logic [43:0] page);
        @(negedge clk);
        inv_en = 1; inv_op = op; inv_asid = asid; inv_page = page;
        @(negedge clk);
        inv_en = 0;
    endtask

    task automatic chk(input string rq, input logic [55:0] va,
                       input logic [15:0] asid, input logic eh,
                       input logic [47:0] epa, input logic [9:0] eat);
        lk_va = va; lk_asid = asid;
        #1;
        n_chk++;
        if (lk_hit !== eh || lk_pa !== (eh ? epa : 48'd0) ||
            lk_attr !== (eh ? eat : 10'd0)) begin
            n_fail++;
            $display("FAIL %s va=%h asid=%h: hit=%0b pa=%h attr=%h expected hit=%0b pa=%h attr=%h",
                     rq, va, asid, lk_hit, lk_pa, lk_attr, eh,
                     eh ? epa : 48'd0, eh ? eat : 10'd0);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        logic [55:0] va, vb, vc;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: empty after reset
        for (int k = 0; k < 4; k++)
            chk("R1", 56'h12_3456_789A_BC00 << k, 16'(k), 0, 0, 0);

        // R2 R4 R3: every size code
        for (int s = 0; s < 8; s++) begin
            logic [35:0] pfn;
            va  = 56'hA5_5A3C_1234_5678;
            pfn = 36'h9_8765_4321 ^ 36'(s);
            fill(va, 16'h0005, 0, s, pfn);
            chk("R2", va, 16'h0005, 1, exp_pa(va, s, pfn), attr_of(pfn));
            vb = va ^ (56'd1 << (bits_of(s) - 1));
            chk("R4", vb, 16'h0005, 1, exp_pa(vb, s, pfn), attr_of(pfn));
            chk("R4", va ^ (56'd1 << bits_of(s)), 16'h0005, 0, 0, 0);
            chk("R4", va ^ (56'd1 << 55), 16'h0005, 0, 0, 0);
            chk("R3", va, 16'h0006, 0, 0, 0);
            inv(2'd0, 0, 0);
            // R5
            chk("R5", va, 16'h0005, 0, 0, 0);
        end

        // R3: global matches every identifier
        va = 56'h00_0000_4000_0000;
        fill(va, 16'h0001, 1, 0, 36'h111);
        for (int a = 0; a < 8; a++)
            chk("R3", va, 16'(a * 16'h2101), 1, exp_pa(va, 0, 36'h111), attr_of(36'h111));
        inv(2'd0, 0, 0);

        // R6: identifier invalidation spares globals and other identifiers
        va = 56'h00_0000_0001_0000; vb = 56'h00_0000_0002_0000; vc = 56'h00_0000_0003_0000;
        fill(va, 16'h0001, 0, 0, 36'hA);
        fill(vb, 16'h0002, 0, 0, 36'hB);
        fill(vc, 16'h0009, 1, 0, 36'hC);
        inv(2'd1, 16'h0001, 0);
        chk("R6", va, 16'h0001, 0, 0, 0);
        chk("R6", vb, 16'h0002, 1, exp_pa(vb, 0, 36'hB), attr_of(36'hB));
        chk("R6", vc, 16'h0001, 1, exp_pa(vc, 0, 36'hC), attr_of(36'hC));
        inv(2'd0, 0, 0);

        // R7: page within identifier, globals for that page also go
        fill(va, 16'h0001, 0, 0, 36'hA);
        fill(va, 16'h0002, 0, 0, 36'hD);
        fill(vc, 16'h0009, 1, 0, 36'hC);
        inv(2'd2, 16'h0001, va[55:12]);
        chk("R7", va, 16'h0001, 0, 0, 0);
        chk("R7", va, 16'h0002, 1, exp_pa(va, 0, 36'hD), attr_of(36'hD));
        chk("R7", vc, 16'h0003, 1, exp_pa(vc, 0, 36'hC), attr_of(36'hC));
        inv(2'd2, 16'h0003, vc[55:12]);
        chk("R7", vc, 16'h0003, 0, 0, 0);
        inv(2'd0, 0, 0);

        // R8: page in any identifier
        fill(va, 16'h0001, 0, 0, 36'hA);
        fill(va, 16'h0002, 0, 0, 36'hD);
        fill(vb, 16'h0001, 0, 0, 36'hB);
        inv(2'd3, 16'h0077, va[55:12]);
        chk("R8", va, 16'h0001, 0, 0, 0);
        chk("R8", va, 16'h0002, 0, 0, 0);
        chk("R8", vb, 16'h0001, 1, exp_pa(vb, 0, 36'hB), attr_of(36'hB));
        inv(2'd0, 0, 0);

        // R9: interior page of a 2 MiB block removes the block
        va = 56'h00_0012_3440_0000;
        fill(va, 16'h0004, 0, 3, 36'h5_5000);
        chk("R9", va + 56'h1_2345, 16'h0004, 1, exp_pa(va + 56'h1_2345, 3, 36'h5_5000), attr_of(36'h5_5000));
        inv(2'd3, 0, va[55:12] + 44'h5);
        chk("R9", va, 16'h0004, 0, 0, 0);

        // R10: invalidate-all and fill in one cycle keeps the fill
        fill(vb, 16'h0001, 0, 0, 36'hB);
        @(negedge clk);
        inv_en = 1; inv_op = 2'd0;
        fill_en = 1; fill_vpn = va[55:12]; fill_asid = 16'h0004;
        fill_global = 0; fill_size = 3'd0; fill_pfn = 36'hE; fill_attr = attr_of(36'hE);
        @(negedge clk);
        inv_en = 0; fill_en = 0;
        chk("R10", va, 16'h0004, 1, exp_pa(va, 0, 36'hE), attr_of(36'hE));
        chk("R10", vb, 16'h0001, 0, 0, 0);
        inv(2'd0, 0, 0);

        // R11: free slots first, then round robin
        for (int i = 0; i < 16; i++)
            fill(56'(i + 1) << 20, 16'h0007, 0, 0, 36'(i + 100));
        for (int i = 0; i < 16; i++)
            chk("R11", 56'(i + 1) << 20, 16'h0007, 1,
                exp_pa(56'(i + 1) << 20, 0, 36'(i + 100)), attr_of(36'(i + 100)));
        fill(56'd17 << 20, 16'h0007, 0, 0, 36'd200);
        chk("R11", 56'd1 << 20, 16'h0007, 0, 0, 0);
        chk("R11", 56'd2 << 20, 16'h0007, 1, exp_pa(56'd2 << 20, 0, 36'd101), attr_of(36'd101));
        fill(56'd18 << 20, 16'h0007, 0, 0, 36'd201);
        chk("R11", 56'd2 << 20, 16'h0007, 0, 0, 0);
        inv(2'd3, 0, 44'd6 << 8);
        fill(56'd19 << 20, 16'h0007, 0, 0, 36'd202);
        chk("R11", 56'd3 << 20, 16'h0007, 1, exp_pa(56'd3 << 20, 0, 36'd102), attr_of(36'd102));
        chk("R11", 56'd19 << 20, 16'h0007, 1, exp_pa(56'd19 << 20, 0, 36'd202), attr_of(36'd202));
        fill(56'd20 << 20, 16'h0007, 0, 0, 36'd203);
        chk("R11", 56'd3 << 20, 16'h0007, 0, 0, 0);
        chk("R11", 56'd4 << 20, 16'h0007, 1, exp_pa(56'd4 << 20, 0, 36'd103), attr_of(36'd103));
        chk("R11", 56'd20 << 20, 16'h0007, 1, exp_pa(56'd20 << 20, 0, 36'd203), attr_of(36'd203));

        summary();
    end
endmodule